// File: doc/BRIEF.md
# LCD Serial Command/Data Transmitter

This block is a transmit-only serial engine for feeding words to a display controller over a clocked serial link. Software or a DMA channel writes one word at a time, together with a command/data flag, into a single-entry holding buffer. When the serial engine is free, it moves the word into its own shift register and sends 8, 16, 18 or 24 data bits, most significant bit first.

The command/data flag is sent in one of two ways. In in-band mode it goes out as an extra serial bit ahead of the data. In pin mode it appears as a level on a separate `a0` output for the whole frame. Clock polarity and phase can be set at run time, which gives four timing modes. The bit rate comes from a programmable divider. A level interrupt and a DMA request both show that the holding buffer is empty. If the next word is in the buffer when the last bit of a frame ends, chip-select stays low and the next frame follows with no gap.

Top module: `lcd_serial_tx`

## Requirements
- R1: `cfg_len` sets the data length: 0 selects 8 bits, 1 selects 16, 2 selects 18 and 3 selects 24. The data comes from the low bits of `wr_data` and is sent most significant bit first on `sdo`.
- R2: With `cfg_a0_mode`=0 (in-band), the flag is the first serial bit of the frame, so a frame has N+1 bits. In this mode `a0` stays 0.
- R3: With `cfg_a0_mode`=1, a frame has N bits. `a0` takes the word's flag in the cycle `cs_n` falls and does not change while `cs_n` stays low.
- R4: While `cs_n` is high, `sclk` rests at `cfg_cpol`. Each bit lasts two half-periods of `cfg_div`+1 clocks each. In the first half-period `sclk` equals `cfg_cpol` when `cfg_cpha`=0 and its inverse when `cfg_cpha`=1. It toggles in the second half-period.
- R5: When the engine is idle and the buffer holds a word, `cs_n` falls one clock later. At the end of a frame `cs_n` stays low only if a word is already buffered and, in pin mode, that word has the same flag. Otherwise `cs_n` goes high for at least one clock.
- R6: A write is accepted only while the buffer is empty. A write while the buffer is full is dropped and never sent.
- R7: `irq_txe` is high exactly while the buffer is empty. It is high in the cycle `cs_n` falls.
- R8: `dma_req` is high exactly when `dma_en` is 1 and the buffer is empty.
- R9: After reset, `cs_n`=1, `sclk`=`cfg_cpol`, `sdo`=0, `a0`=0 and `irq_txe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 24 | Word to send, right-aligned |
| wr_cmd | input | 1 | Command/data flag sent with the word |
| cfg_len | input | 2 | Data length select (see R1) |
| cfg_a0_mode | input | 1 | 1: flag on the `a0` pin; 0: flag as a leading serial bit |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_div | input | DIV_W | Half-period length minus one, in clocks |
| dma_en | input | 1 | Enables the DMA request |
| irq_txe | output | 1 | Holding buffer empty |
| dma_req | output | 1 | DMA request |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| a0 | output | 1 | Command/data level in pin mode |

## Verification
The bench targets these corner cases:

- **Frame-boundary chaining.** A design that reloads late would pulse `cs_n` high between buffered words. One that ignores the pin-mode flag rule would change `a0` while `cs_n` is low.
- **Write while full.** A design that overwrites the buffer would send the second word instead of the first.
- **Divide-by-two and 25-bit frames.** An off-by-one in the half-period or bit counter would shorten or lengthen the `cs_n` low time.
- **CPHA=1.** Getting the phase wrong would move every `sclk` edge by half a bit against the reference.

// File: rtl/lcd_tx_pkg.sv
package lcd_tx_pkg;
   localparam int MAX_BITS = 24;
   localparam int FRAME_W  = MAX_BITS + 1;
   localparam int BCNT_W   = $clog2(FRAME_W + 1);

   typedef enum logic [1:0] {
      LEN_8  = 2'd0,
      LEN_16 = 2'd1,
      LEN_18 = 2'd2,
      LEN_24 = 2'd3
   } len_sel_e;

   typedef struct packed {
      logic [MAX_BITS-1:0] data;
      logic                cmd;
   } tx_word_t;

   function automatic int unsigned len_of(input int unsigned sel);
      case (sel)
         0:       return 8;
         1:       return 16;
         2:       return 18;
         default: return 24;
      endcase
   endfunction
endpackage

// File: rtl/lcd_tx_hold_buf.sv
module lcd_tx_hold_buf
   import lcd_tx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  tx_word_t wr_word,
   input  logic     take,
   output logic     valid,
   output tx_word_t word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         word  <= '0;
      end else if (take) begin
         valid <= 1'b0;
      end else if (wr_en && !valid) begin
         valid <= 1'b1;
         word  <= wr_word;
      end
   end
endmodule

// File: rtl/lcd_tx_framer.sv
module lcd_tx_framer
   import lcd_tx_pkg::*;
(
   input  tx_word_t           word,
   input  len_sel_e           len_sel,
   input  logic               inband,
   output logic [FRAME_W-1:0] frame,
   output logic [BCNT_W-1:0]  nbits
);
   logic [MAX_BITS-1:0] aligned [4];
   logic [BCNT_W-1:0]   lens    [4];

   for (genvar g = 0; g < 4; g++) begin : g_len
      localparam int L = len_of(g);
      assign aligned[g] = word.data << (MAX_BITS - L);
      assign lens[g]    = BCNT_W'(L);
   end

   always_comb begin
      if (inband) frame = {word.cmd, aligned[len_sel]};
      else        frame = {aligned[len_sel], 1'b0};
      nbits = lens[len_sel] + BCNT_W'(inband);
   end
endmodule

// File: rtl/lcd_tx_shifter.sv
module lcd_tx_shifter
   import lcd_tx_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   cfg_div,
   input  logic               cfg_cpol,
   input  logic               cfg_cpha,
   input  logic               cfg_a0_mode,
   input  logic               have_word,
   input  logic               word_cmd,
   input  logic [FRAME_W-1:0] frame,
   input  logic [BCNT_W-1:0]  nbits,
   output logic               take,
   output logic               sclk,
   output logic               sdo,
   output logic               cs_n,
   output logic               a0
);
   logic               active, half, a0_q;
   logic [DIV_W-1:0]   hcnt;
   logic [BCNT_W-1:0]  bitcnt;
   logic [FRAME_W-1:0] shreg;
   logic               tick, last_edge, may_chain;

   assign tick      = (hcnt == cfg_div);
   assign last_edge = active && tick && half && (bitcnt == '0);
   assign may_chain = !cfg_a0_mode || (word_cmd == a0_q);
   assign take      = have_word && (!active || (last_edge && may_chain));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         half   <= 1'b0;
         hcnt   <= '0;
         bitcnt <= '0;
         shreg  <= '0;
         a0_q   <= 1'b0;
      end else if (take) begin
         active <= 1'b1;
         half   <= 1'b0;
         hcnt   <= '0;
         bitcnt <= nbits - BCNT_W'(1);
         shreg  <= frame;
         if (cfg_a0_mode) a0_q <= word_cmd;
      end else if (active) begin
         if (!tick) begin
            hcnt <= hcnt + DIV_W'(1);
         end else begin
            hcnt <= '0;
            half <= !half;
            if (half) begin
               if (bitcnt == '0) begin
                  active <= 1'b0;
               end else begin
                  bitcnt <= bitcnt - BCNT_W'(1);
                  shreg  <= {shreg[FRAME_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign sclk = active ? (cfg_cpol ^ cfg_cpha ^ half) : cfg_cpol;
   assign sdo  = active & shreg[FRAME_W-1];
   assign cs_n = !active;
   assign a0   = cfg_a0_mode & a0_q;
endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx
   import lcd_tx_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_cmd,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_a0_mode,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              dma_en,
   output logic              irq_txe,
   output logic              dma_req,
   output logic              sclk,
   output logic              sdo,
   output logic              cs_n,
   output logic              a0
);
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must lie in 1..16");
   end
   if (DATA_W != MAX_BITS) begin : g_bad_data
      $error("DATA_W must equal the longest frame length");
   end

   tx_word_t           in_word, buf_word;
   logic               buf_valid, take;
   logic [FRAME_W-1:0] frame;
   logic [BCNT_W-1:0]  nbits;

   assign in_word = '{data: wr_data, cmd: wr_cmd};

   lcd_tx_hold_buf u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(in_word),
      .take(take), .valid(buf_valid), .word(buf_word)
   );

   lcd_tx_framer u_frm (
      .word(buf_word), .len_sel(len_sel_e'(cfg_len)), .inband(!cfg_a0_mode),
      .frame(frame), .nbits(nbits)
   );

   lcd_tx_shifter #(.DIV_W(DIV_W)) u_shf (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_a0_mode(cfg_a0_mode), .have_word(buf_valid),
      .word_cmd(buf_word.cmd), .frame(frame), .nbits(nbits), .take(take),
      .sclk(sclk), .sdo(sdo), .cs_n(cs_n), .a0(a0)
   );

   assign irq_txe = !buf_valid;
   assign dma_req = dma_en & !buf_valid;
endmodule

// File: rtl/lcd_serial_tx_chk.sv
module lcd_serial_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic cfg_a0_mode,
   input logic cfg_cpol,
   input logic irq_txe,
   input logic dma_req,
   input logic sclk,
   input logic cs_n,
   input logic a0
);
   AST_A0_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(a0)); // R3
   AST_A0_ZERO_INBAND: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_a0_mode |-> !a0); // R2
   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sclk == cfg_cpol)); // R4
   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_txe && wr_en && !cs_n) |=> !irq_txe); // R6
   AST_EMPTY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> irq_txe); // R7
   AST_DMA_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> irq_txe); // R8
endmodule

bind lcd_serial_tx lcd_serial_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_a0_mode(cfg_a0_mode),
   .cfg_cpol(cfg_cpol), .irq_txe(irq_txe), .dma_req(dma_req),
   .sclk(sclk), .cs_n(cs_n), .a0(a0)
);

// File: tb/test_lcd_serial_tx.sv
module test_lcd_serial_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [23:0] wr_data = '0;
   logic        wr_cmd = 1'b0;
   logic [1:0]  cfg_len = 2'd0;
   logic        cfg_a0_mode = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [7:0]  cfg_div = 8'd1;
   logic        dma_en = 1'b0;
   logic        irq_txe, dma_req, sclk, sdo, cs_n, a0;

   always #5 clk = ~clk;

   lcd_serial_tx i_lcd_serial_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_cmd(wr_cmd),
      .cfg_len(cfg_len), .cfg_a0_mode(cfg_a0_mode), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .dma_en(dma_en),
      .irq_txe(irq_txe), .dma_req(dma_req), .sclk(sclk), .sdo(sdo),
      .cs_n(cs_n), .a0(a0)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit          m_bv, m_bc, m_act, m_half, m_a0, m_wr_ok;
   logic [23:0] m_bd;
   int          m_hc;
   bit          fq[$];

   function automatic int lenbits(input logic [1:0] s);
      return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 18 : 24;
   endfunction

   task automatic start_frame();
      fq.delete();
      if (!cfg_a0_mode) fq.push_back(m_bc);
      for (int i = lenbits(cfg_len) - 1; i >= 0; i--) fq.push_back(m_bd[i]);
      if (cfg_a0_mode) m_a0 = m_bc;
      m_act = 1; m_half = 0; m_hc = 0; m_bv = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_bv = 0; m_act = 0; m_half = 0; m_hc = 0; m_a0 = 0; fq.delete();
      end else begin
         m_wr_ok = wr_en && !m_bv;
         if (!m_act) begin
            if (m_bv) start_frame();
         end else if (m_hc == int'(cfg_div)) begin
            m_hc = 0;
            if (!m_half) m_half = 1;
            else begin
               m_half = 0;
               void'(fq.pop_front());
               if (fq.size() == 0) begin
                  if (m_bv && (!cfg_a0_mode || m_bc == m_a0)) start_frame();
                  else m_act = 0;
               end
            end
         end else m_hc++;
         if (m_wr_ok) begin m_bv = 1; m_bd = wr_data; m_bc = wr_cmd; end
      end
   end

   int  cs_falls = 0, cs_low = 0;
   bit  prev_cs = 1;
   always @(negedge clk) begin
      bit e_sclk, e_sdo;
      e_sclk = cfg_cpol;
      if (m_act) e_sclk = cfg_cpol ^ cfg_cpha ^ m_half;
      e_sdo = m_act ? fq[0] : 1'b0;
      chk(cs_n == !m_act, "R5 cs_n", cs_n, !m_act);
      chk(sclk == e_sclk, "R4 sclk", sclk, e_sclk);
      chk(sdo == e_sdo, "R1 sdo", sdo, e_sdo);
      chk(a0 == (cfg_a0_mode ? m_a0 : 1'b0), "R3 a0", a0, cfg_a0_mode ? m_a0 : 1'b0);
      chk(irq_txe == !m_bv, "R7 irq_txe", irq_txe, !m_bv);
      chk(dma_req == (dma_en && !m_bv), "R8 dma_req", dma_req, dma_en && !m_bv);
      if (prev_cs && !cs_n) cs_falls++;
      if (!cs_n) cs_low++;
      prev_cs = cs_n;
   end

   task automatic write_word(input logic [23:0] d, input logic c);
      @(posedge clk); #1;
      wr_en = 1; wr_data = d; wr_cmd = c;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic wait_empty();
      @(negedge clk);
      while (!irq_txe) @(negedge clk);
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (!(cs_n && irq_txe)) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int f0, l0;
      repeat (3) @(negedge clk);
      chk(cs_n == 1, "R9 reset cs_n", cs_n, 1);
      chk(sclk == 0, "R9 reset sclk", sclk, 0);
      chk(sdo == 0, "R9 reset sdo", sdo, 0);
      chk(a0 == 0, "R9 reset a0", a0, 0);
      chk(irq_txe == 1, "R9 reset irq_txe", irq_txe, 1);
      #3 rst_n = 1;

      // R2: in-band, 8 bits, div 1 -> 2*9*2 clocks low
      f0 = cs_falls; l0 = cs_low;
      write_word(24'h0000A5, 1'b1);
      wait_idle();
      chk(cs_falls - f0 == 1, "R5 single frame", cs_falls - f0, 1);
      chk(cs_low - l0 == 36, "R2 in-band frame length", cs_low - l0, 36);

      // R3: pin mode, 16 bits, cpol 1, chained same flag
      cfg_a0_mode = 1; cfg_len = 2'd1; cfg_cpol = 1; cfg_div = 8'd2;
      f0 = cs_falls;
      write_word(24'h00C3E1, 1'b0);
      wait_empty();
      write_word(24'h005A0F, 1'b0);
      wait_idle();
      chk(cs_falls - f0 == 1, "R5 chained frames keep cs low", cs_falls - f0, 1);

      // R3: flag change forces a gap
      f0 = cs_falls;
      write_word(24'h001111, 1'b1);
      wait_empty();
      write_word(24'h002222, 1'b0);
      wait_idle();
      chk(cs_falls - f0 == 2, "R3 flag change splits frames", cs_falls - f0, 2);

      // R8/R6: 18 bits, in-band, cpha 1, write while full dropped
      cfg_a0_mode = 0; cfg_len = 2'd2; cfg_cpol = 0; cfg_cpha = 1; cfg_div = 8'd1;
      dma_en = 1;
      @(negedge clk);
      chk(dma_req == 1, "R8 dma_req when empty", dma_req, 1);
      f0 = cs_falls;
      @(posedge clk); #1;
      wr_en = 1; wr_data = 24'h2ABCD; wr_cmd = 0;
      @(posedge clk); #1;
      wr_data = 24'h15432; wr_cmd = 1;
      @(posedge clk); #1;
      wr_en = 0;
      @(negedge clk);
      chk(irq_txe == 1, "R6 second write dropped", irq_txe, 1);
      wait_idle();
      chk(cs_falls - f0 == 1, "R6 only first word sent", cs_falls - f0, 1);
      dma_en = 0;

      // R1: 24 bits, mode 3, divide by two, three chained words
      cfg_len = 2'd3; cfg_cpol = 1; cfg_cpha = 1; cfg_div = 8'd0;
      f0 = cs_falls; l0 = cs_low;
      write_word(24'hF0F0F0, 1'b1);
      for (int k = 0; k < 2; k++) begin
         wait_empty();
         write_word(24'h123456 + 24'(k * 24'h111111), 1'b0);
      end
      wait_idle();
      chk(cs_falls - f0 == 1, "R5 three chained words", cs_falls - f0, 1);
      chk(cs_low - l0 == 150, "R1 25-bit frames at div 0", cs_low - l0, 150);

      // R1/R3: 24 bits pin mode, div 3 -> 2*24*4 clocks
      cfg_a0_mode = 1; cfg_cpol = 0; cfg_cpha = 0; cfg_div = 8'd3;
      l0 = cs_low;
      write_word(24'h800001, 1'b1);
      wait_idle();
      chk(cs_low - l0 == 192, "R1 pin-mode 24-bit length", cs_low - l0, 192);

      finish_run();
   end
endmodule